// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer. It maps a 32-bit virtual address to a physical address in one combinational pass. Each of its entries covers two neighbouring 4 KB pages, an even page and an odd page. The two pages share one tag, one address-space identifier (ASID) and one global flag. Each page has its own frame number, valid bit and dirty bit.

A requester presents an address, a read/write flag and the current 8-bit ASID. In the same cycle it gets back a 3-bit status code, the physical address and a write-permission flag. Entries are loaded one at a time through a write port that takes an index. Refill software and replacement choice are left to the surrounding system.

The block is purely a datapath. It has no sequencing states. The only state is the entry storage, which is cleared at reset and updated on the clock edge that follows a write request.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset every entry holds zero in all fields, valid bits included. No lookup can return MATCH or DIRTY until an entry is written. A lookup whose tag is non-zero returns NOMATCH.
- R2: An entry hits when its tag equals the address bits above bit 12 (bits 31:13), and either its global flag is set or its stored ASID equals the current ASID.
- R3: Address bit 12 selects the half of the hit entry: 0 selects the even half and 1 selects the odd half.
- R4: If the selected half has its valid bit clear, the status is INVALID (3'b101), for both reads and writes.
- R5: On MATCH (3'b000) the physical address is the selected 20-bit frame number in bits 31:12, with the address offset (bits 11:0) passed through unchanged in bits 11:0.
- R6: On MATCH the write-permission flag equals the selected dirty bit, and read permission is always granted. On any other status, both the physical address and the write-permission flag are zero.
- R7: A write that hits a valid half whose dirty bit is clear returns DIRTY (3'b100). A read of the same half returns MATCH.
- R8: When no entry hits, the status is NOMATCH (3'b110). The code 3'b111 is reserved for a bad-address result and is never produced by this block.
- R9: When several entries hit, the lowest-indexed one supplies the result.
- R10: A write request loads the entry at the given index on the next clock edge. Lookups in the same cycle still see the old contents, and all other entries are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_is_write | input | 1 | 1 = store access, 0 = load access |
| lk_asid | input | 8 | Current address-space identifier |
| lk_paddr | output | 32 | Translated address (zero unless MATCH) |
| lk_can_write | output | 1 | Write permission (MATCH only) |
| lk_status | output | 3 | Result code: 000 MATCH, 110 NOMATCH, 101 INVALID, 100 DIRTY |
| wr_en | input | 1 | Load an entry on this edge |
| wr_idx | input | 4 | Index of the entry to load |
| wr_tag | input | 19 | Page-pair tag (address bits 31:13) |
| wr_asid | input | 8 | ASID stored with the entry |
| wr_global | input | 1 | Match regardless of ASID |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |

## Verification
The assertions watch the consistency of the result on every cycle:
- write permission appears only with MATCH;
- non-MATCH results carry a zero address;
- the page offset survives translation;
- DIRTY follows only a write;
- the code is always one of the four legal values;
- nothing leaves reset translated.

Only the bench scenarios can show that the right entry and the right half were chosen. These scenarios cover:
- ASID mismatch against global bypass;
- even/odd selection;
- lowest-index priority among duplicate tags;
- the one-edge delay of the write port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 12;
    parameter int ASID_W    = 8;
    localparam int TAG_W    = VA_W - PAGE_BITS - 1;
    localparam int PFN_W    = VA_W - PAGE_BITS;

    typedef enum logic [2:0] {
        ST_MATCH   = 3'b000,
        ST_DIRTY   = 3'b100,
        ST_INVALID = 3'b101,
        ST_NOMATCH = 3'b110,
        ST_BADADDR = 3'b111
    } tlb_status_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn_even;
        logic              v_even;
        logic              d_even;
        logic [PFN_W-1:0]  pfn_odd;
        logic              v_odd;
        logic              d_odd;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_data,
    output tlb_entry_t [NUM_ENTRIES-1:0] entries
);
    tlb_entry_t [NUM_ENTRIES-1:0] store_q;

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                store_q[gi] <= wr_data;
            end
        end
    end

    assign entries = store_q;
endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [TAG_W-1:0]             probe_tag,
    input  logic [ASID_W-1:0]            probe_asid,
    output logic [NUM_ENTRIES-1:0]       hit_vec
);
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
        logic space_ok;
        assign space_ok    = entries[gi].glob || (entries[gi].asid == probe_asid);
        assign hit_vec[gi] = space_ok && (entries[gi].tag == probe_tag);
    end
endmodule

// File: rtl/tlb_priority_pick.sv
module tlb_priority_pick #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);
    always_comb begin
        any_hit = |hit_vec;
        win_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_is_write,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [VA_W-1:0]   lk_paddr,
    output logic              lk_can_write,
    output logic [2:0]        lk_status,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic [PFN_W-1:0]  wr_pfn_even,
    input  logic              wr_valid_even,
    input  logic              wr_dirty_even,
    input  logic [PFN_W-1:0]  wr_pfn_odd,
    input  logic              wr_valid_odd,
    input  logic              wr_dirty_odd
);
    tlb_entry_t                   wr_data;
    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    logic [NUM_ENTRIES-1:0]       hit_vec;
    logic                         any_hit;
    logic [IDX_W-1:0]             win_idx;
    tlb_entry_t                   chosen;
    logic                         odd_half;
    logic [PFN_W-1:0]             sel_pfn;
    logic                         sel_valid;
    logic                         sel_dirty;
    tlb_status_e                  status_c;

    always_comb begin
        wr_data.tag      = wr_tag;
        wr_data.asid     = wr_asid;
        wr_data.glob     = wr_global;
        wr_data.pfn_even = wr_pfn_even;
        wr_data.v_even   = wr_valid_even;
        wr_data.d_even   = wr_dirty_even;
        wr_data.pfn_odd  = wr_pfn_odd;
        wr_data.v_odd    = wr_valid_odd;
        wr_data.d_odd    = wr_dirty_odd;
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .entries (entries)
    );

    tlb_match_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .entries    (entries),
        .probe_tag  (lk_vaddr[VA_W-1:PAGE_BITS+1]),
        .probe_asid (lk_asid),
        .hit_vec    (hit_vec)
    );

    tlb_priority_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    assign chosen   = entries[win_idx];
    assign odd_half = lk_vaddr[PAGE_BITS];

    always_comb begin
        if (odd_half) begin
            sel_pfn   = chosen.pfn_odd;
            sel_valid = chosen.v_odd;
            sel_dirty = chosen.d_odd;
        end else begin
            sel_pfn   = chosen.pfn_even;
            sel_valid = chosen.v_even;
            sel_dirty = chosen.d_even;
        end
    end

    always_comb begin
        if (!any_hit)                      status_c = ST_NOMATCH;
        else if (!sel_valid)               status_c = ST_INVALID;
        else if (lk_is_write && !sel_dirty) status_c = ST_DIRTY;
        else                               status_c = ST_MATCH;
    end

    always_comb begin
        lk_status    = status_c;
        lk_paddr     = '0;
        lk_can_write = 1'b0;
        unique case (status_c)
            ST_MATCH: begin
                lk_paddr     = {sel_pfn, lk_vaddr[PAGE_BITS-1:0]};
                lk_can_write = sel_dirty;
            end
            ST_DIRTY, ST_INVALID, ST_NOMATCH, ST_BADADDR: begin
                lk_paddr     = '0;
                lk_can_write = 1'b0;
            end
            default: begin
                lk_paddr     = '0;
                lk_can_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker
    import tlb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [PAGE_BITS-1:0] lk_offset,
    input logic                 lk_is_write,
    input logic [VA_W-1:0]      lk_paddr,
    input logic                 lk_can_write,
    input logic [2:0]           lk_status
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lk_status != 3'b000 && lk_status != 3'b100));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status == 3'b000) |-> (lk_paddr[PAGE_BITS-1:0] == lk_offset));

    a_r6_write_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        lk_can_write |-> (lk_status == 3'b000));

    a_r6_quiet_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status != 3'b000) |-> (lk_paddr == '0 && !lk_can_write));

    a_r7_dirty_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status == 3'b100) |-> lk_is_write);

    a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status == 3'b000 || lk_status == 3'b100 ||
         lk_status == 3'b101 || lk_status == 3'b110));
endmodule

bind tlb_lookup_unit tlb_lookup_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_offset    (lk_vaddr[tlb_pkg::PAGE_BITS-1:0]),
    .lk_is_write  (lk_is_write),
    .lk_paddr     (lk_paddr),
    .lk_can_write (lk_can_write),
    .lk_status    (lk_status)
);

// File: tb/tlb_lookup_unit_bench.sv
module tlb_lookup_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_is_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic [31:0] lk_paddr;
    logic        lk_can_write;
    logic [2:0]  lk_status;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_tag = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn_even = '0;
    logic        wr_valid_even = 1'b0;
    logic        wr_dirty_even = 1'b0;
    logic [19:0] wr_pfn_odd = '0;
    logic        wr_valid_odd = 1'b0;
    logic        wr_dirty_odd = 1'b0;

    localparam logic [2:0] S_MATCH = 3'b000, S_DIRTY = 3'b100,
                           S_INVAL = 3'b101, S_NOMAT = 3'b110;

    typedef struct {
        logic [2:0]  st;
        logic [31:0] pa;
        logic        w;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    tlb_lookup_unit u_tlb_lookup_unit (.*);

    function automatic void compare(exp_t e);
        n_checks++;
        if (lk_status !== e.st || lk_paddr !== e.pa || lk_can_write !== e.w) begin
            n_fail++;
            $display("FAIL %s: got st=%b pa=%h w=%b, expected st=%b pa=%h w=%b",
                     e.req, lk_status, lk_paddr, lk_can_write, e.st, e.pa, e.w);
        end
    endfunction

    // monitor: pops one expectation per cycle, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    task automatic lookup(input logic [31:0] va, input logic wr, input logic [7:0] asid,
                          input logic [2:0] st, input logic [31:0] pa, input logic w,
                          input string req);
        exp_t e;
        @(negedge clk);
        lk_vaddr = va; lk_is_write = wr; lk_asid = asid;
        e.st = st; e.pa = pa; e.w = w; e.req = req;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    task automatic load(input logic [3:0] idx, input logic [18:0] tag, input logic [7:0] asid,
                        input logic g, input logic [19:0] pe, input logic ve, input logic de,
                        input logic [19:0] po, input logic vo, input logic dov);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_asid = asid; wr_global = g;
        wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
        wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dov;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: empty after reset
        lookup(32'h0040_0123, 1'b0, 8'h11, S_NOMAT, 32'h0, 1'b0, "R1 empty nonzero tag");
        lookup(32'h0000_0010, 1'b0, 8'h00, S_INVAL, 32'h0, 1'b0, "R1 zeroed entry tag0 asid0");

        load(4'd2, 19'h00200, 8'h11, 1'b0, 20'h12345, 1'b1, 1'b1, 20'h0ABCD, 1'b1, 1'b0);
        lookup(32'h0040_0123, 1'b0, 8'h11, S_MATCH, 32'h1234_5123, 1'b1, "R5 even read");
        lookup(32'h0040_1ABC, 1'b0, 8'h11, S_MATCH, 32'h0ABC_DABC, 1'b0, "R3 odd read clean");
        lookup(32'h0040_1ABC, 1'b1, 8'h11, S_DIRTY, 32'h0, 1'b0, "R7 write to clean half");
        lookup(32'h0040_0FFF, 1'b1, 8'h11, S_MATCH, 32'h1234_5FFF, 1'b1, "R6 write to dirty half");
        lookup(32'h0040_0123, 1'b0, 8'h22, S_NOMAT, 32'h0, 1'b0, "R2 asid mismatch");
        lookup(32'h0040_2000, 1'b0, 8'h11, S_NOMAT, 32'h0, 1'b0, "R8 tag mismatch");

        load(4'd5, 19'h7FFFF, 8'h99, 1'b1, 20'hFFFFF, 1'b0, 1'b1, 20'h00001, 1'b1, 1'b1);
        lookup(32'hFFFF_E004, 1'b0, 8'h00, S_INVAL, 32'h0, 1'b0, "R4 invalid even half read");
        lookup(32'hFFFF_E004, 1'b1, 8'h33, S_INVAL, 32'h0, 1'b0, "R4 invalid even half write");
        lookup(32'hFFFF_F010, 1'b1, 8'h33, S_MATCH, 32'h0000_1010, 1'b1, "R2 global bypass");

        // R9: duplicates, lowest index wins
        load(4'd9, 19'h00200, 8'h11, 1'b0, 20'h55555, 1'b1, 1'b1, 20'h55555, 1'b1, 1'b1);
        lookup(32'h0040_0040, 1'b0, 8'h11, S_MATCH, 32'h1234_5040, 1'b1, "R9 entry2 over entry9");
        load(4'd1, 19'h00200, 8'h11, 1'b0, 20'h77777, 1'b1, 1'b1, 20'h77777, 1'b1, 1'b1);
        lookup(32'h0040_1040, 1'b1, 8'h11, S_MATCH, 32'h7777_7040, 1'b1, "R9 entry1 over entry2");

        // R10: same-cycle lookup sees old contents, next cycle sees new
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd1; wr_tag = 19'h00201; wr_asid = 8'h11; wr_global = 1'b0;
        lk_vaddr = 32'h0040_0040; lk_is_write = 1'b0; lk_asid = 8'h11;
        #1 begin
            exp_t e;
            e.st = S_MATCH; e.pa = 32'h7777_7040; e.w = 1'b1; e.req = "R10 old value before edge";
            compare(e);
        end
        @(posedge clk);
        #1 wr_en = 1'b0;
        #1 begin
            exp_t e;
            e.st = S_MATCH; e.pa = 32'h1234_5040; e.w = 1'b1; e.req = "R10 new value after edge";
            compare(e);
        end
        lookup(32'hFFFF_F010, 1'b0, 8'h01, S_MATCH, 32'h0000_1010, 1'b1, "R10 other entry kept");

        // R1: reset again clears everything
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        lookup(32'hFFFF_F010, 1'b0, 8'h01, S_NOMAT, 32'h0, 1'b0, "R1 cleared after second reset");

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule